// File: doc/BRIEF.md
# Rotating-Parity Block Array Controller

This controller places single-block host requests onto nine storage lanes. Each stripe holds eight data blocks and one parity block. The parity block moves to a different lane on each successive stripe, so no single lane carries all of the parity traffic. The controller accepts one host request at a time and sends per-lane read and write requests through simple valid/ready channels. It collects each lane's response, together with that lane's error flag, and answers the host on a valid/ready response channel.

A read normally touches only the lane that holds the block. If that lane flags an error, the controller reads the other eight lanes of the stripe and returns their XOR. A write is a read-modify-write: it first fetches the old data and the old parity, then writes the new data and a parity value adjusted by the change in data. If the data lane errors during this step, the old data is never needed: the parity is rebuilt from the seven untouched data blocks and the new data. If the parity lane errors, no write is issued and the host gets an error.

Back-pressure: the host request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while the controller is idle. Once `rsp_valid` rises, it and the response fields stay unchanged until `rsp_ready` is seen. Each lane request stays asserted, with its address, write flag and data unchanged, until that lane's ready is high. Lane responses have no back-pressure and must arrive at least one cycle after the request was accepted.

Top module: `striped_parity_ctrl`

## Requirements
- R1: For logical block number L, the stripe is s = L / 8 and the slot is k = L mod 8. The parity lane is p = 8 - (s mod 9). The data lane is k when k < p, and k + 1 otherwise. Every lane request carries s as its address.
- R2: A read whose data lane returns no error issues exactly one lane read, on the data lane. It returns that lane's data with `rsp_err` = 0.
- R3: When the data lane flags an error on a read, the other eight lanes of the stripe are read. The XOR of their data is returned with `rsp_err` = 0.
- R4: If any of those eight reconstruction reads also flags an error, `rsp_err` = 1.
- R5: A write with no lane error reads only the data lane and the parity lane. It then writes only those two lanes: the data lane gets the new block, and the parity lane gets old parity XOR old data XOR new data.
- R6: A write is acknowledged only after both lane writes have been answered. When `rsp_valid` is high, no lane request is pending.
- R7: If the parity lane flags an error during the pre-read of a write, the response has `rsp_err` = 1 and no lane is written.
- R8: If only the data lane flags an error during the pre-read of a write, the seven other data lanes are read. Parity is written as their XOR with the new data, the new data is written, and `rsp_err` = 0.
- R9: Only one host request is in progress at a time. `req_ready` is 1 only when idle and never while `rsp_valid` is 1. A stalled response holds its value.
- R10: A lane request that is not accepted keeps its valid, write flag and address until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller idle, request may be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_lba | input | LBA_W | Logical block number |
| req_wdata | input | BLK_W | Block to write |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Host takes the response |
| rsp_rdata | output | BLK_W | Read block (zero for writes) |
| rsp_err | output | 1 | Uncorrectable error |
| lane_req_valid | output | NL | Per-lane request valid |
| lane_req_ready | input | NL | Per-lane request ready |
| lane_req_write | output | NL | Per-lane write flag |
| lane_req_addr | output | NL*SW | Per-lane stripe address, lane i at bits [i*SW +: SW] |
| lane_req_wdata | output | NL*BLK_W | Per-lane write block |
| lane_rsp_valid | input | NL | Per-lane response valid |
| lane_rsp_rdata | input | NL*BLK_W | Per-lane read block |
| lane_rsp_err | input | NL | Per-lane read error flag |

## Verification
No result has a fixed latency. The host answer arrives a number of cycles after acceptance that depends on the lane models: each lane model stalls its ready at random and answers one to three cycles after taking a request. A clean read therefore answers after one lane round trip plus two cycles. A degraded read or a write adds one or two further round trips. The bench does not count cycles. It drives and samples on falling edges and waits for `rsp_valid`. At the first falling edge where `rsp_valid` is seen, it compares the returned block, the error flag and the lane read and write counts against values it computes itself. Lane-side handshake hold is checked on every falling edge.

// File: rtl/spc_pkg.sv
package spc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,   // waiting for host request
    ST_RD,     // single-lane read in flight
    ST_DEG,    // reconstruction reads in flight
    ST_WPRE,   // old data + old parity reads
    ST_WRCN,   // rebuild parity from other data lanes
    ST_WISS,   // launch the two writes
    ST_WWR,    // writes in flight
    ST_RSP     // holding host response
  } ctrl_state_e;
endpackage

// File: rtl/stripe_map.sv
module stripe_map #(
  parameter int DATA_LANES = 8,
  parameter int LBA_W      = 16,
  localparam int NL = DATA_LANES + 1,
  localparam int KW = $clog2(DATA_LANES),
  localparam int SW = LBA_W - KW,
  localparam int LW = $clog2(NL)
) (
  input  logic [LBA_W-1:0] lba,
  output logic [SW-1:0]    stripe,
  output logic [LW-1:0]    dlane,
  output logic [LW-1:0]    plane
);
  localparam logic [SW-1:0] NL_S  = SW'(NL);
  localparam logic [LW-1:0] TOP_L = LW'(NL - 1);

  logic [LW-1:0] rot;
  logic [LW-1:0] slot;

  always_comb begin
    stripe = lba[LBA_W-1:KW];
    slot   = LW'(lba[KW-1:0]);
    rot    = LW'(stripe % NL_S);
    plane  = TOP_L - rot;
    dlane  = (slot < plane) ? slot : slot + LW'(1);
  end
endmodule

// File: rtl/lane_gather.sv
module lane_gather #(
  parameter int NL    = 9,
  parameter int BLK_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [NL-1:0]       start_mask,
  input  logic                start_write,
  output logic                busy,
  output logic                done,
  output logic [BLK_W-1:0]    acc,
  output logic [NL-1:0]       errm,
  output logic [NL-1:0]       lane_req_valid,
  input  logic [NL-1:0]       lane_req_ready,
  output logic [NL-1:0]       lane_req_write,
  input  logic [NL-1:0]       lane_rsp_valid,
  input  logic [NL*BLK_W-1:0] lane_rsp_rdata,
  input  logic [NL-1:0]       lane_rsp_err
);
  logic [NL-1:0]    pend_issue, pend_rsp, hit, fire;
  logic             write_q;
  logic [BLK_W-1:0] acc_n;

  assign lane_req_valid = pend_issue;
  assign lane_req_write = {NL{write_q}};
  assign hit  = lane_rsp_valid & pend_rsp & ~pend_issue;
  assign fire = pend_issue & lane_req_ready;

  always_comb begin
    acc_n = acc;
    for (int i = 0; i < NL; i++)
      if (hit[i]) acc_n = acc_n ^ lane_rsp_rdata[i*BLK_W +: BLK_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_issue <= '0;
      pend_rsp   <= '0;
      acc        <= '0;
      errm       <= '0;
      write_q    <= 1'b0;
      busy       <= 1'b0;
      done       <= 1'b0;
    end else if (start) begin
      pend_issue <= start_mask;
      pend_rsp   <= start_mask;
      acc        <= '0;
      errm       <= '0;
      write_q    <= start_write;
      busy       <= |start_mask;
      done       <= 1'b0;
    end else begin
      pend_issue <= pend_issue & ~fire;
      pend_rsp   <= pend_rsp & ~hit;
      acc        <= acc_n;
      errm       <= errm | (hit & lane_rsp_err);
      done       <= busy && ((pend_rsp & ~hit) == '0);
      if (busy && ((pend_rsp & ~hit) == '0)) busy <= 1'b0;
    end
  end

  // a new batch must not be launched over an unfinished one
  assert_start_when_free_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);

  generate
    for (genvar g = 0; g < NL; g++) begin : g_hold
      assert_lane_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_req_valid[g] && !lane_req_ready[g]) |=>
          (lane_req_valid[g] && $stable(lane_req_write[g])));
    end
  endgenerate
endmodule

// File: rtl/striped_parity_ctrl.sv
module striped_parity_ctrl
  import spc_pkg::*;
#(
  parameter int DATA_LANES = 8,
  parameter int BLK_W      = 32,
  parameter int LBA_W      = 16,
  localparam int NL = DATA_LANES + 1,
  localparam int KW = $clog2(DATA_LANES),
  localparam int SW = LBA_W - KW,
  localparam int LW = $clog2(NL)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [LBA_W-1:0]    req_lba,
  input  logic [BLK_W-1:0]    req_wdata,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [BLK_W-1:0]    rsp_rdata,
  output logic                rsp_err,
  output logic [NL-1:0]       lane_req_valid,
  input  logic [NL-1:0]       lane_req_ready,
  output logic [NL-1:0]       lane_req_write,
  output logic [NL*SW-1:0]    lane_req_addr,
  output logic [NL*BLK_W-1:0] lane_req_wdata,
  input  logic [NL-1:0]       lane_rsp_valid,
  input  logic [NL*BLK_W-1:0] lane_rsp_rdata,
  input  logic [NL-1:0]       lane_rsp_err
);
  ctrl_state_e      state;
  logic [SW-1:0]    m_stripe, stripe_q;
  logic [LW-1:0]    m_dlane, m_plane, dlane_q, plane_q;
  logic             write_q, err_q;
  logic [BLK_W-1:0] wdata_q, par_q, rdata_q;
  logic [NL-1:0]    d_oh, p_oh, md_oh, mp_oh;

  logic             g_start, g_write, g_busy, g_done;
  logic [NL-1:0]    g_mask, g_errm;
  logic [BLK_W-1:0] g_acc;

  stripe_map #(.DATA_LANES(DATA_LANES), .LBA_W(LBA_W)) u_map (
    .lba(req_lba), .stripe(m_stripe), .dlane(m_dlane), .plane(m_plane)
  );

  lane_gather #(.NL(NL), .BLK_W(BLK_W)) u_gather (
    .clk(clk), .rst_n(rst_n),
    .start(g_start), .start_mask(g_mask), .start_write(g_write),
    .busy(g_busy), .done(g_done), .acc(g_acc), .errm(g_errm),
    .lane_req_valid(lane_req_valid), .lane_req_ready(lane_req_ready),
    .lane_req_write(lane_req_write), .lane_rsp_valid(lane_rsp_valid),
    .lane_rsp_rdata(lane_rsp_rdata), .lane_rsp_err(lane_rsp_err)
  );

  assign d_oh  = NL'(1) << dlane_q;
  assign p_oh  = NL'(1) << plane_q;
  assign md_oh = NL'(1) << m_dlane;
  assign mp_oh = NL'(1) << m_plane;

  generate
    for (genvar g = 0; g < NL; g++) begin : g_lane
      assign lane_req_addr[g*SW +: SW]        = stripe_q;
      assign lane_req_wdata[g*BLK_W +: BLK_W] = (dlane_q == LW'(g)) ? wdata_q : par_q;
    end
  endgenerate

  assign req_ready = (state == ST_IDLE);
  assign rsp_valid = (state == ST_RSP);
  assign rsp_rdata = rdata_q;
  assign rsp_err   = err_q;

  // batch launch decisions
  always_comb begin
    g_start = 1'b0;
    g_mask  = '0;
    g_write = 1'b0;
    unique case (state)
      ST_IDLE: if (req_valid) begin
        g_start = 1'b1;
        g_mask  = req_write ? (md_oh | mp_oh) : md_oh;
      end
      ST_RD: if (g_done && g_errm != '0) begin
        g_start = 1'b1;
        g_mask  = ~d_oh;
      end
      ST_WPRE: if (g_done && (g_errm & p_oh) == '0 && (g_errm & d_oh) != '0) begin
        g_start = 1'b1;
        g_mask  = ~(d_oh | p_oh);
      end
      ST_WISS: begin
        g_start = 1'b1;
        g_mask  = d_oh | p_oh;
        g_write = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      stripe_q <= '0;
      dlane_q  <= '0;
      plane_q  <= '0;
      write_q  <= 1'b0;
      wdata_q  <= '0;
      par_q    <= '0;
      rdata_q  <= '0;
      err_q    <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (req_valid) begin
          stripe_q <= m_stripe;
          dlane_q  <= m_dlane;
          plane_q  <= m_plane;
          write_q  <= req_write;
          wdata_q  <= req_wdata;
          state    <= req_write ? ST_WPRE : ST_RD;
        end
        ST_RD: if (g_done) begin
          if (g_errm == '0) begin
            rdata_q <= g_acc;
            err_q   <= 1'b0;
            state   <= ST_RSP;
          end else begin
            state <= ST_DEG;
          end
        end
        ST_DEG: if (g_done) begin
          rdata_q <= g_acc;
          err_q   <= |g_errm;
          state   <= ST_RSP;
        end
        ST_WPRE: if (g_done) begin
          if ((g_errm & p_oh) != '0) begin
            rdata_q <= '0;
            err_q   <= 1'b1;
            state   <= ST_RSP;
          end else if ((g_errm & d_oh) != '0) begin
            state <= ST_WRCN;
          end else begin
            par_q <= g_acc ^ wdata_q;
            state <= ST_WISS;
          end
        end
        ST_WRCN: if (g_done) begin
          if (g_errm != '0) begin
            rdata_q <= '0;
            err_q   <= 1'b1;
            state   <= ST_RSP;
          end else begin
            par_q <= g_acc ^ wdata_q;
            state <= ST_WISS;
          end
        end
        ST_WISS: state <= ST_WWR;
        ST_WWR: if (g_done) begin
          rdata_q <= '0;
          err_q   <= 1'b0;
          state   <= ST_RSP;
        end
        ST_RSP: if (rsp_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=>
      (rsp_valid && $stable(rsp_rdata) && $stable(rsp_err)));

  assert_single_flight_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && rsp_valid));

  assert_lanes_distinct_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |-> (dlane_q != plane_q));

  assert_write_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|(lane_req_valid & lane_req_write)) |-> ((lane_req_valid & ~(d_oh | p_oh)) == '0));

  assert_quiet_on_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (lane_req_valid == '0 && !g_busy));

  assert_no_write_on_perr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WPRE && g_done && (g_errm & p_oh) != '0) |=> (state == ST_RSP && err_q));
endmodule

// File: tb/striped_parity_ctrl_bench.sv
module striped_parity_ctrl_bench;
  localparam int NL = 9;
  localparam int BW = 32;
  localparam int LBA_W = 16;
  localparam int SW = 13;
  localparam int NS = 16;
  localparam int NB = NS * 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic             req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b0;
  logic [LBA_W-1:0] req_lba = '0;
  logic [BW-1:0]    req_wdata = '0;
  logic             req_ready, rsp_valid, rsp_err;
  logic [BW-1:0]    rsp_rdata;
  logic [NL-1:0]    lane_req_valid, lane_req_write;
  logic [NL-1:0]    lane_req_ready = '0, lane_rsp_valid = '0, lane_rsp_err = '0;
  logic [NL*SW-1:0] lane_req_addr;
  logic [NL*BW-1:0] lane_req_wdata;
  logic [NL*BW-1:0] lane_rsp_rdata = '0;

  striped_parity_ctrl u_striped_parity_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_lba(req_lba), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .lane_req_valid(lane_req_valid), .lane_req_ready(lane_req_ready),
    .lane_req_write(lane_req_write), .lane_req_addr(lane_req_addr),
    .lane_req_wdata(lane_req_wdata), .lane_rsp_valid(lane_rsp_valid),
    .lane_rsp_rdata(lane_rsp_rdata), .lane_rsp_err(lane_rsp_err)
  );

  function automatic int par_lane(int s); return 8 - (s % 9); endfunction
  function automatic int dat_lane(int s, int k);
    return (k < par_lane(s)) ? k : k + 1;
  endfunction
  function automatic logic [BW-1:0] seedval(int lba);
    return (32'(lba) * 32'h9E3779B1) ^ 32'h5A5A0000;
  endfunction

  // lane models: storage, error injection, counters
  logic [BW-1:0] mem [NL][NS];
  bit            err_map [NL][NS];
  int            rd_cnt [NL], wr_cnt [NL], wack_cnt [NL];
  int            hold_viol;
  bit            pend [NL], p_wr [NL], pv [NL], pr [NL], pwr_q [NL];
  int            dly [NL], p_addr [NL];
  logic [SW-1:0] paddr_q [NL];

  always @(negedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NS; s++) begin
        logic [BW-1:0] px;
        px = '0;
        for (int k = 0; k < 8; k++) begin
          mem[dat_lane(s, k)][s] = seedval(s * 8 + k);
          px = px ^ seedval(s * 8 + k);
        end
        mem[par_lane(s)][s] = px;
      end
      for (int i = 0; i < NL; i++) begin
        rd_cnt[i] = 0; wr_cnt[i] = 0; wack_cnt[i] = 0;
        pend[i] = 0; pv[i] = 0; pr[i] = 0;
      end
      hold_viol = 0;
      lane_req_ready = '0;
      lane_rsp_valid = '0;
    end else begin
      for (int i = 0; i < NL; i++) begin
        lane_rsp_valid[i] = 1'b0;
        lane_rsp_err[i]   = 1'b0;
        if (pend[i]) begin
          if (dly[i] == 0) begin
            lane_rsp_valid[i] = 1'b1;
            if (p_wr[i]) begin
              lane_rsp_rdata[i*BW +: BW] = '0;
              wack_cnt[i]++;
            end else if (err_map[i][p_addr[i]]) begin
              lane_rsp_rdata[i*BW +: BW] = ~mem[i][p_addr[i]];
              lane_rsp_err[i] = 1'b1;
            end else begin
              lane_rsp_rdata[i*BW +: BW] = mem[i][p_addr[i]];
            end
            pend[i] = 0;
          end else dly[i]--;
        end
        if (pv[i] && !pr[i] && (!lane_req_valid[i] ||
            lane_req_addr[i*SW +: SW] != paddr_q[i] || lane_req_write[i] != pwr_q[i]))
          hold_viol++;
        pv[i] = lane_req_valid[i];
        paddr_q[i] = lane_req_addr[i*SW +: SW];
        pwr_q[i] = lane_req_write[i];
        lane_req_ready[i] = !pend[i] && ($urandom % 4 != 0);
        pr[i] = lane_req_ready[i];
        if (lane_req_ready[i] && lane_req_valid[i]) begin
          p_addr[i] = int'(lane_req_addr[i*SW +: SW]);
          p_wr[i] = lane_req_write[i];
          if (p_wr[i]) begin
            mem[i][p_addr[i]] = lane_req_wdata[i*BW +: BW];
            wr_cnt[i]++;
          end else rd_cnt[i]++;
          pend[i] = 1;
          dly[i] = $urandom % 3;
        end
      end
    end
  end

  int total = 0, bad = 0;
  logic [BW-1:0] gold [NB];
  int d_rd [NL], d_wr [NL];
  int ack_wacks;
  bit busy_ready_seen;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [BW-1:0] act, input logic [BW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic host_op(input bit wr, input int lba, input logic [BW-1:0] wd,
                         input int hold, output logic [BW-1:0] rd, output bit er);
    int rd0 [NL], wr0 [NL], wa0;
    logic [BW-1:0] first_d;
    bit first_e;
    wa0 = 0;
    for (int i = 0; i < NL; i++) begin
      rd0[i] = rd_cnt[i]; wr0[i] = wr_cnt[i]; wa0 += wack_cnt[i];
    end
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_lba = LBA_W'(lba); req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    busy_ready_seen = 0;
    while (!rsp_valid) begin
      if (req_ready) busy_ready_seen = 1;
      @(negedge clk);
    end
    if (req_ready) busy_ready_seen = 1;
    ack_wacks = -wa0;
    for (int i = 0; i < NL; i++) ack_wacks += wack_cnt[i];
    first_d = rsp_rdata; first_e = rsp_err;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_rdata == first_d && rsp_err == first_e, "R9",
          "stalled response held", rsp_rdata, first_d);
    end
    rsp_ready = 1'b1;
    rd = rsp_rdata; er = rsp_err;
    @(negedge clk);
    rsp_ready = 1'b0;
    for (int i = 0; i < NL; i++) begin
      d_rd[i] = rd_cnt[i] - rd0[i]; d_wr[i] = wr_cnt[i] - wr0[i];
    end
  endtask

  function automatic int sum_rd(); int t = 0;
    for (int i = 0; i < NL; i++) t += d_rd[i]; return t; endfunction
  function automatic int sum_wr(); int t = 0;
    for (int i = 0; i < NL; i++) t += d_wr[i]; return t; endfunction

  task automatic chk_stripe(input int s, input string req);
    logic [BW-1:0] px;
    px = '0;
    for (int k = 0; k < 8; k++) begin
      chk(mem[dat_lane(s, k)][s] == gold[s*8+k], req, "data lane contents",
          mem[dat_lane(s, k)][s], gold[s*8+k]);
      px = px ^ gold[s*8+k];
    end
    chk(mem[par_lane(s)][s] == px, req, "parity lane contents", mem[par_lane(s)][s], px);
  endtask

  task automatic clear_errs();
    for (int i = 0; i < NL; i++) for (int s = 0; s < NS; s++) err_map[i][s] = 0;
  endtask

  initial begin
    logic [BW-1:0] rd;
    bit er;
    int lbas [5];
    void'($urandom(32'd1234));
    clear_errs();
    for (int b = 0; b < NB; b++) gold[b] = seedval(b);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk(!rsp_valid, "R9", "rsp_valid after reset", 32'(rsp_valid), 0);
    chk(req_ready, "R9", "req_ready after reset", 32'(req_ready), 1);
    chk(lane_req_valid == '0, "R10", "lane valid after reset", 32'(lane_req_valid), 0);

    // R1/R2: mapping corners, clean reads touch one lane
    lbas = '{0, 7, 64, 37, 35};
    foreach (lbas[j]) begin
      int s, k;
      s = lbas[j] / 8; k = lbas[j] % 8;
      host_op(0, lbas[j], '0, 0, rd, er);
      chk(rd == gold[lbas[j]] && !er, "R2", "clean read data", rd, gold[lbas[j]]);
      chk(d_rd[dat_lane(s, k)] == 1 && sum_rd() == 1, "R1", "read lane index",
          32'(sum_rd()), 1);
      chk(!busy_ready_seen, "R9", "req_ready low while busy", 32'(busy_ready_seen), 0);
    end

    // R3: degraded read
    err_map[dat_lane(4, 5)][4] = 1;
    host_op(0, 37, '0, 0, rd, er);
    chk(rd == gold[37] && !er, "R3", "rebuilt block", rd, gold[37]);
    chk(sum_rd() == 9, "R3", "reads in degraded path", 32'(sum_rd()), 9);

    // R4: second failure
    err_map[par_lane(4)][4] = 1;
    host_op(0, 37, '0, 0, rd, er);
    chk(er, "R4", "double failure flagged", 32'(er), 1);
    clear_errs();

    // R5/R6: clean small write with stalled response
    host_op(1, 37, 32'hCAFE_0037, 3, rd, er);
    gold[37] = 32'hCAFE_0037;
    chk(!er, "R5", "write err flag", 32'(er), 0);
    chk(d_rd[dat_lane(4, 5)] == 1 && d_rd[par_lane(4)] == 1 && sum_rd() == 2, "R5",
        "pre-read lanes", 32'(sum_rd()), 2);
    chk(d_wr[dat_lane(4, 5)] == 1 && d_wr[par_lane(4)] == 1 && sum_wr() == 2, "R5",
        "written lanes", 32'(sum_wr()), 2);
    chk(ack_wacks == 2, "R6", "write answers before ack", 32'(ack_wacks), 2);
    chk_stripe(4, "R5");
    host_op(0, 37, '0, 0, rd, er);
    chk(rd == gold[37], "R5", "read back after write", rd, gold[37]);

    // R7: parity lane error blocks the write (stripe 8, parity on lane 0)
    err_map[par_lane(8)][8] = 1;
    host_op(1, 66, 32'hDEAD_0066, 0, rd, er);
    chk(er, "R7", "parity error flagged", 32'(er), 1);
    chk(sum_wr() == 0, "R7", "no lane written", 32'(sum_wr()), 0);
    clear_errs();
    chk_stripe(8, "R7");

    // R8: data lane error rebuilds parity
    err_map[dat_lane(8, 2)][8] = 1;
    host_op(1, 66, 32'hBEEF_0066, 0, rd, er);
    gold[66] = 32'hBEEF_0066;
    chk(!er, "R8", "write err flag", 32'(er), 0);
    chk(sum_rd() == 9 && sum_wr() == 2, "R8", "rebuild reads", 32'(sum_rd()), 9);
    clear_errs();
    chk_stripe(8, "R8");

    // random mix with occasional single-lane errors
    for (int n = 0; n < 150; n++) begin
      int lba, s, el;
      bit wr, inj;
      logic [BW-1:0] wd;
      lba = int'($urandom % NB); s = lba / 8;
      wr = $urandom % 2; wd = $urandom;
      inj = ($urandom % 5) == 0; el = int'($urandom % NL);
      if (inj) err_map[el][s] = 1;
      host_op(wr, lba, wd, int'($urandom % 3), rd, er);
      clear_errs();
      if (!wr) begin
        chk(rd == gold[lba] && !er, "R3", "random read", rd, gold[lba]);
      end else if (inj && el == par_lane(s)) begin
        chk(er && sum_wr() == 0, "R7", "random write parity error", 32'(sum_wr()), 0);
      end else begin
        gold[lba] = wd;
        chk(!er && sum_wr() == 2, "R5", "random write", 32'(sum_wr()), 2);
        chk(ack_wacks == 2, "R6", "random write ack order", 32'(ack_wacks), 2);
      end
      chk_stripe(s, "R8");
    end

    chk(hold_viol == 0, "R10", "lane request dropped or changed before accept",
        32'(hold_viol), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    bad++; total++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule